// File: doc/BRIEF.md
# Max-Deficit Head-Cache Refill Scheduler

This block keeps the books for a small per-queue head cache that sits in front of a wide, slow bulk memory in a packet buffer. Each cycle is one timeslot. In a timeslot it accepts at most one byte-read request, tagged with a queue index, and at most one byte-arrival notice that adds a byte to that queue's backlog in bulk memory. It keeps two counters for every queue: cache occupancy and bulk backlog.

The decision timeslots are spaced `REFILL` cycles apart. In each one the block picks one queue to be topped up with a `REFILL`-byte block from bulk memory. It chooses the eligible queue whose shortfall from the cache limit `CACHE_W` is largest. It then emits a one-cycle command that carries the queue index. The counters change on the same clock edge that raises the command. For the cache never to run dry, the cache limit must be at least about `REFILL*(2+ln NUM_Q)`. A read that finds an empty cache sets a sticky error flag.

Top module: `refill_sched`

## Requirements
- R1: After reset, every occupancy is 0, every backlog is 0, `rep_valid` is 0 and `underflow_err` is 0.
- R2: Decision slots fall on the cycles where a free-running slot counter, cleared by reset, equals `REFILL-1`. A command appears on `rep_valid` after the rising edge that ends such a slot, which is edge number `k*REFILL` after reset release. It is never high in any other cycle, and it is never high in two consecutive cycles.
- R3: Of the eligible queues, the command names the one with the largest deficit, where deficit equals `CACHE_W` minus occupancy. Deficits are evaluated on the counter values during the decision slot.
- R4: When several eligible queues share the largest deficit, the lowest queue index is chosen.
- R5: A queue is eligible only if its backlog is at least `REFILL` bytes. The backlog rises by 1 for each arrival and saturates at its maximum. It falls by `REFILL` for each command that names the queue.
- R6: A queue is eligible only if its deficit is at least `REFILL`, so its occupancy never goes above `CACHE_W`.
- R7: If no queue is eligible in a decision slot, no command is issued in that window.
- R8: A command adds `REFILL` to the named queue's occupancy on the same edge that raises `rep_valid`.
- R9: A read of queue q whose occupancy is nonzero lowers that occupancy by 1 on the next edge.
- R10: A read of a queue whose occupancy is 0 sets `underflow_err`, which stays 1 until reset. That read removes nothing, so the occupancy does not drop.
- R11: A read and a refill of the same queue in the same cycle are applied together, with a net change of `REFILL-1`, or of `REFILL` when the queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | A byte is read from a queue's cache head this slot |
| rd_qid | input | $clog2(NUM_Q) | Queue index of the read |
| arr_valid | input | 1 | A byte joins a queue's bulk backlog this slot |
| arr_qid | input | $clog2(NUM_Q) | Queue index of the arrival |
| rep_valid | output | 1 | One-cycle refill command |
| rep_qid | output | $clog2(NUM_Q) | Queue named by the refill command |
| underflow_err | output | 1 | Sticky flag set by a read of an empty cache |
| occ_flat | output | NUM_Q*$clog2(CACHE_W+1) | Per-queue occupancy, queue i at bits [i*OB +: OB] |

## Verification
The bench targets deficit ties between queues that become eligible in the same window. A design with a reversed comparison would pick the higher index. It checks a queue whose backlog sits one byte below `REFILL`; an off-by-one eligibility test would refill that queue too early. It fills a queue all the way to `CACHE_W`; without the room test the occupancy would climb past the limit. It also checks reads of empty queues and reads that coincide with a refill of the same queue. A design that lets the counter wrap there, or drops one of the two updates, would show a wrong occupancy on the next cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;
    localparam int unsigned DEF_NUM_Q        = 8;
    localparam int unsigned DEF_REFILL       = 4;
    localparam int unsigned DEF_CACHE_W      = 24;
    localparam int unsigned DEF_BACKLOG_BITS = 8;
endpackage

// File: rtl/sched_qctr.sv
module sched_qctr #(
    parameter int unsigned REFILL   = 4,
    parameter int unsigned CACHE_W  = 24,
    parameter int unsigned OCC_BITS = 5,
    parameter int unsigned BL_BITS  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_hit,
    input  logic                arr_hit,
    input  logic                rep_hit,
    output logic [OCC_BITS-1:0] occ,
    output logic [BL_BITS-1:0]  backlog,
    output logic                empty_rd
);
    localparam logic [OCC_BITS-1:0] REF_OCC = OCC_BITS'(REFILL);
    localparam logic [BL_BITS-1:0]  REF_BL  = BL_BITS'(REFILL);

    typedef struct packed {
        logic [OCC_BITS-1:0] occ;
        logic [BL_BITS-1:0]  bl;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        empty_rd = rd_hit && (cnt_q.occ == '0);
        if (rd_hit && (cnt_q.occ != '0)) cnt_d.occ = cnt_d.occ - 1'b1;
        if (rep_hit)                     cnt_d.occ = cnt_d.occ + REF_OCC;
        if (arr_hit && (cnt_q.bl != '1)) cnt_d.bl  = cnt_d.bl + 1'b1;
        if (rep_hit)                     cnt_d.bl  = cnt_d.bl - REF_BL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign occ     = cnt_q.occ;
    assign backlog = cnt_q.bl;

    // R6
    occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q.occ) <= CACHE_W);

    // R10
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && cnt_q.occ == '0 && !rep_hit) |=> (cnt_q.occ == '0));

    // R5
    backlog_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_hit |-> (32'(cnt_q.bl) >= REFILL));
endmodule

// File: rtl/sched_maxpick.sv
module sched_maxpick #(
    parameter int unsigned NUM_Q    = 8,
    parameter int unsigned DEF_BITS = 5,
    parameter int unsigned QID_BITS = 3
) (
    input  logic [NUM_Q-1:0]          elig,
    input  logic [NUM_Q*DEF_BITS-1:0] deficit_flat,
    output logic                      found,
    output logic [QID_BITS-1:0]       idx
);
    logic [DEF_BITS-1:0] best_def;

    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_def = '0;
        for (int i = 0; i < int'(NUM_Q); i++) begin
            if (elig[i] && (!found || deficit_flat[i*DEF_BITS +: DEF_BITS] > best_def)) begin
                found    = 1'b1;
                idx      = QID_BITS'(i);
                best_def = deficit_flat[i*DEF_BITS +: DEF_BITS];
            end
        end
    end
endmodule

// File: rtl/refill_sched.sv
module refill_sched
    import sched_pkg::*;
#(
    parameter int unsigned NUM_Q        = DEF_NUM_Q,
    parameter int unsigned REFILL       = DEF_REFILL,
    parameter int unsigned CACHE_W      = DEF_CACHE_W,
    parameter int unsigned BACKLOG_BITS = DEF_BACKLOG_BITS,
    localparam int unsigned QID_BITS    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int unsigned OCC_BITS    = $clog2(CACHE_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_valid,
    input  logic [QID_BITS-1:0]       rd_qid,
    input  logic                      arr_valid,
    input  logic [QID_BITS-1:0]       arr_qid,
    output logic                      rep_valid,
    output logic [QID_BITS-1:0]       rep_qid,
    output logic                      underflow_err,
    output logic [NUM_Q*OCC_BITS-1:0] occ_flat
);
    localparam int unsigned SLOT_BITS = (REFILL > 1) ? $clog2(REFILL) : 1;
    localparam logic [SLOT_BITS-1:0] LAST_SLOT = SLOT_BITS'(REFILL - 1);

    typedef struct packed {
        logic [SLOT_BITS-1:0] slot;
        logic                 rep_valid;
        logic [QID_BITS-1:0]  rep_qid;
        logic                 err;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_Q-1:0]          elig;
    logic [NUM_Q-1:0]          empty_rd;
    logic [NUM_Q*OCC_BITS-1:0] deficit_flat;
    logic [OCC_BITS-1:0]       occ_arr [NUM_Q];
    logic                      found;
    logic [QID_BITS-1:0]       pick_idx;
    logic                      dec_fire;

    assign dec_fire = (st_q.slot == LAST_SLOT) && found;

    for (genvar g = 0; g < int'(NUM_Q); g++) begin : g_queue
        logic [BACKLOG_BITS-1:0] bl;
        logic [OCC_BITS-1:0]     def;

        sched_qctr #(
            .REFILL  (REFILL),
            .CACHE_W (CACHE_W),
            .OCC_BITS(OCC_BITS),
            .BL_BITS (BACKLOG_BITS)
        ) i_qctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_hit  (rd_valid && (rd_qid == QID_BITS'(g))),
            .arr_hit (arr_valid && (arr_qid == QID_BITS'(g))),
            .rep_hit (dec_fire && (pick_idx == QID_BITS'(g))),
            .occ     (occ_arr[g]),
            .backlog (bl),
            .empty_rd(empty_rd[g])
        );

        assign def  = OCC_BITS'(CACHE_W) - occ_arr[g];
        assign elig[g] = (32'(bl) >= REFILL) && (32'(def) >= REFILL);
        assign deficit_flat[g*OCC_BITS +: OCC_BITS] = def;
        assign occ_flat[g*OCC_BITS +: OCC_BITS]     = occ_arr[g];
    end

    sched_maxpick #(
        .NUM_Q   (NUM_Q),
        .DEF_BITS(OCC_BITS),
        .QID_BITS(QID_BITS)
    ) i_pick (
        .elig        (elig),
        .deficit_flat(deficit_flat),
        .found       (found),
        .idx         (pick_idx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.slot      = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
        st_d.rep_valid = dec_fire;
        st_d.rep_qid   = dec_fire ? pick_idx : st_q.rep_qid;
        st_d.err       = st_q.err || (|empty_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rep_valid     = st_q.rep_valid;
    assign rep_qid       = st_q.rep_qid;
    assign underflow_err = st_q.err;

    // R2
    rep_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |=> !rep_valid);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);

    // R8
    rep_filled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && 32'(rep_qid) < NUM_Q) |-> (32'(occ_arr[rep_qid]) + 1 >= REFILL));

    // R3
    rep_qid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid |-> (32'(rep_qid) < NUM_Q));
endmodule

// File: tb/test_refill_sched.sv
module test_refill_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NQ  = 8;
    localparam int B   = 4;
    localparam int W   = 24;
    localparam int BLB = 8;
    localparam int QB  = $clog2(NQ);
    localparam int OB  = $clog2(W + 1);
    localparam int BL_MAX = (1 << BLB) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_valid = 1'b0;
    logic [QB-1:0] rd_qid = '0;
    logic arr_valid = 1'b0;
    logic [QB-1:0] arr_qid = '0;
    logic rep_valid;
    logic [QB-1:0] rep_qid;
    logic underflow_err;
    logic [NQ*OB-1:0] occ_flat;

    int checks = 0;
    int errors = 0;
    int m_occ [NQ];
    int m_bl  [NQ];
    int m_slot, m_rv, m_rq, m_err;
    int saw_rep;

    always #(CLK_PERIOD/2) clk = ~clk;

    refill_sched #(.NUM_Q(NQ), .REFILL(B), .CACHE_W(W), .BACKLOG_BITS(BLB)) i_refill_sched (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_qid(rd_qid),
        .arr_valid(arr_valid), .arr_qid(arr_qid), .rep_valid(rep_valid),
        .rep_qid(rep_qid), .underflow_err(underflow_err), .occ_flat(occ_flat));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int occ_of(int q);
        return int'(occ_flat[q*OB +: OB]);
    endfunction

    // largest deficit among queues with backlog >= B and deficit >= B, lowest index on ties
    function automatic int pick();
        int best = -1;
        int bd = -1;
        for (int q = 0; q < NQ; q++) begin
            if (m_bl[q] >= B && (W - m_occ[q]) >= B && (W - m_occ[q]) > bd) begin
                best = q;
                bd = W - m_occ[q];
            end
        end
        return best;
    endfunction

    task automatic compare();
        chk("R2 R7 rep_valid", int'(rep_valid), m_rv);
        if (m_rv != 0) chk("R3 R4 rep_qid", int'(rep_qid), m_rq);
        chk("R10 underflow_err", int'(underflow_err), m_err);
        for (int q = 0; q < NQ; q++) chk("R8 R9 R11 occupancy", occ_of(q), m_occ[q]);
    endtask

    // drive one timeslot at a falling edge, advance model, check after the next rising edge
    task automatic step(bit rv, int rq, bit av, int aq);
        int sel;
        rd_valid = rv; rd_qid = QB'(rq);
        arr_valid = av; arr_qid = QB'(aq);
        sel = (m_slot == B - 1) ? pick() : -1;
        if (rv) begin
            if (m_occ[rq] == 0) m_err = 1;
            else m_occ[rq]--;
        end
        if (av && m_bl[aq] < BL_MAX) m_bl[aq]++;
        if (sel >= 0) begin
            m_occ[sel] += B;
            m_bl[sel]  -= B;
            m_rq = sel;
        end
        m_rv = (sel >= 0) ? 1 : 0;
        m_slot = (m_slot == B - 1) ? 0 : m_slot + 1;
        @(negedge clk);
        if (rep_valid) saw_rep = 1;
        compare();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int q = 0; q < NQ; q++) begin m_occ[q] = 0; m_bl[q] = 0; end
        m_slot = 0; m_rv = 0; m_rq = 0; m_err = 0; saw_rep = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 rep_valid", int'(rep_valid), 0);
        chk("R1 underflow_err", int'(underflow_err), 0);
        for (int q = 0; q < NQ; q++) chk("R1 occupancy", occ_of(q), 0);

        // R7: nothing eligible, no command
        idle(2 * B);
        chk("R7 no command without eligible queue", saw_rep, 0);

        // R5: backlog one short of B stays ineligible
        for (int i = 0; i < B - 1; i++) step(1'b0, 0, 1'b1, 3);
        idle(B + 1);
        chk("R5 backlog below refill size", saw_rep, 0);
        step(1'b0, 0, 1'b1, 3);
        idle(B - 1);
        chk("R5 backlog reaches refill size", int'(rep_valid), 1);
        chk("R5 refilled queue", int'(rep_qid), 3);

        // R6: fill queue 0 up to the cache limit
        for (int i = 0; i < 32; i++) step(1'b0, 0, 1'b1, 0);
        idle(16);
        chk("R6 occupancy at cache limit", occ_of(0), W);
        saw_rep = 0;
        idle(2 * B);
        chk("R6 full queue not refilled", saw_rep, 0);

        // R4: queues 2 and 5 become eligible in the same window with equal deficits
        for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b1, 5);
        idle(1);
        for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b1, 2);
        step(1'b0, 0, 1'b1, 5);
        idle(3);
        chk("R4 tie goes to lowest index valid", int'(rep_valid), 1);
        chk("R4 tie goes to lowest index", int'(rep_qid), 2);
        idle(B);

        // R9: read of a nonempty queue
        step(1'b1, 0, 1'b0, 0);
        chk("R9 occupancy after read", occ_of(0), W - 1);

        // R10: read of an empty queue
        step(1'b1, 7, 1'b0, 0);
        chk("R10 error raised", int'(underflow_err), 1);
        chk("R10 empty occupancy unchanged", occ_of(7), 0);

        // random traffic, R11 coincidences included
        for (int i = 0; i < 3000; i++) begin
            bit rv = ($urandom % 4) != 0;
            bit av = ($urandom % 8) != 0;
            step(rv, int'($urandom % NQ), av, int'($urandom % NQ));
        end
        idle(2 * B);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule